// File: doc/BRIEF.md
# Priority Scheduler Conformance Monitor

This block watches a preemptive, priority-driven task scheduler from the outside and checks that it dispatches tasks correctly. An upstream decoder hands it two streams: scheduling events (a periodic tick, a task blocking on a semaphore, a release of a blocked task) and the number of the task actually seen executing. The monitor keeps its own replica of the scheduler state: a ready set and a blocked queue, each held in a small associative store looked up by task number, plus a priority table. From these it works out which task must run after each event. It then compares that prediction with the first task observed afterwards.

Priorities are written while the monitor is idle, before a start pulse. A start pulse marks every task ready and clears the blocked queue. It does not clear the error state. A mismatch latches a sticky error flag with a two-bit cause code. Only an explicit clear pulse or a reset removes it.

The controller is a four-state machine:
- `S_IDLE`: configuration allowed. Left by start, which goes to `S_SEL`.
- `S_SEL`: one cycle to register the prediction. Always goes to `S_WAIT`.
- `S_WAIT`: waits for the first observed task, checks it, then goes to `S_RUN`.
- `S_RUN`: accepts the next event and goes back to `S_SEL`.

A start pulse in any state goes to `S_SEL`.

Top module: `sched_monitor`

## Requirements
- R1: After reset the state is `S_IDLE`. `err_flag` is 0, `err_code` is 2'b00 and `expect_valid` is 0.
- R2: A write with `cfg_we` sets the 4-bit priority of task `cfg_task` while in `S_IDLE`. A larger value means a higher priority, and every priority resets to 0. Writes in any other state are ignored.
- R3: On a start pulse, every task becomes ready and none is blocked. Two cycles later the expectation is the highest-priority task, with ties going to the lowest index. `expect_valid` is high only in `S_WAIT`.
- R4: Only the first `obs_valid` after an expectation is compared. The observed task becomes the running task, and later observations are ignored until the next event.
- R5: Event code 2'b00 is a tick. The running task stays ready. The expectation is the ready task of highest priority. Among equal top priorities, the search starts at the index after the running task and wraps, so the running task is chosen again only if no other task shares its priority.
- R6: Event code 2'b01 is a semaphore block. The running task leaves the ready set and joins the tail of the blocked queue. The expectation is then formed as in R5.
- R7: Event code 2'b10 is a release. The oldest blocked task returns to the ready set. The running task is expected to continue unless the released task has strictly higher priority, in which case the highest-priority ready task is expected. A release with an empty blocked queue changes nothing.
- R8: A checked observation sets a cause code, with the earlier case in this list winning:
  - 2'b10: the observed task is in the blocked queue.
  - 2'b11: a release called for preemption but the previously running task was observed.
  - 2'b01: any other mismatch.
- R9: The first error sets `err_flag` and its code. Both hold through later errors and through start pulses until `err_clr` clears them.
- R10: Events arriving outside `S_RUN`, and event code 2'b11 in any state, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse: reset the lists and form a new expectation |
| cfg_we | input | 1 | Priority write strobe (idle only) |
| cfg_task | input | TASK_W | Task whose priority is written |
| cfg_prio | input | PRIO_W | Priority value written |
| evt_valid | input | 1 | Scheduling event strobe |
| evt_kind | input | 2 | 00 tick, 01 block, 10 release, 11 none |
| obs_valid | input | 1 | Observed task strobe |
| obs_task | input | TASK_W | Number of the task seen running |
| err_clr | input | 1 | Clears the sticky error |
| expect_valid | output | 1 | Expectation available while waiting |
| expect_task | output | TASK_W | Task predicted to run next |
| err_flag | output | 1 | Sticky error flag |
| err_code | output | 2 | Cause of the first latched error |

## Verification
A vector table drives a chain of ticks, blocks and releases across three priority levels. This shows that equal-priority tasks are visited in cyclic order, that a lone top task keeps the processor on ticks, and that releases preempt only when the released task has strictly higher priority. Directed cases then feed deliberately wrong observations to produce each cause code, and check that the first code persists when a second fault follows. Further cases send an event while the monitor is waiting, send the no-op code, write a priority after start, send a release with an empty queue, and start from an all-equal priority table to exercise the lowest-index tie rule.

// File: rtl/sched_mon_pkg.sv
package sched_mon_pkg;

    typedef enum logic [1:0] {
        EV_TICK    = 2'b00,
        EV_BLOCK   = 2'b01,
        EV_RELEASE = 2'b10,
        EV_NONE    = 2'b11
    } evt_e;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'b00,
        ERR_WRONG   = 2'b01,
        ERR_BLOCKED = 2'b10,
        ERR_MISSED  = 2'b11
    } err_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'b00,
        S_SEL  = 2'b01,
        S_WAIT = 2'b10,
        S_RUN  = 2'b11
    } mon_state_e;

endpackage

// File: rtl/prio_table.sv
module prio_table #(
    parameter int NUM_TASKS = 16,
    parameter int PRIO_W    = 4,
    parameter int TASK_W    = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [TASK_W-1:0]           wr_task,
    input  logic [PRIO_W-1:0]           wr_prio,
    output logic [NUM_TASKS*PRIO_W-1:0] prio_flat
);

    logic [PRIO_W-1:0] prio_q [NUM_TASKS];

    for (genvar g = 0; g < NUM_TASKS; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prio_q[g] <= '0;
            end else if (wr_en && (wr_task == TASK_W'(g))) begin
                prio_q[g] <= wr_prio;
            end
        end
        assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q[g];
    end

endmodule

// File: rtl/sched_lists.sv
module sched_lists #(
    parameter int NUM_TASKS = 16,
    parameter int TASK_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 init,
    input  logic                 blk,
    input  logic [TASK_W-1:0]    blk_task,
    input  logic                 rel,
    output logic [NUM_TASKS-1:0] ready_mask,
    output logic [NUM_TASKS-1:0] blocked_mask,
    output logic                 head_valid,
    output logic [TASK_W-1:0]    head_task
);

    localparam int CNT_W = $clog2(NUM_TASKS + 1);

    logic [TASK_W-1:0] queue_q [NUM_TASKS];
    logic [TASK_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0]  count;
    logic              push, pop;

    function automatic logic [TASK_W-1:0] wrap_inc(input logic [TASK_W-1:0] p);
        return (p == TASK_W'(NUM_TASKS - 1)) ? '0 : p + 1'b1;
    endfunction

    assign push       = blk && !blocked_mask[blk_task];
    assign pop        = rel && (count != '0);
    assign head_valid = (count != '0);
    assign head_task  = queue_q[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready_mask   <= '0;
            blocked_mask <= '0;
            rd_ptr       <= '0;
            wr_ptr       <= '0;
            count        <= '0;
        end else if (init) begin
            ready_mask   <= '1;
            blocked_mask <= '0;
            rd_ptr       <= '0;
            wr_ptr       <= '0;
            count        <= '0;
        end else if (push) begin
            ready_mask[blk_task]   <= 1'b0;
            blocked_mask[blk_task] <= 1'b1;
            wr_ptr                 <= wrap_inc(wr_ptr);
            count                  <= count + 1'b1;
        end else if (blk) begin
            ready_mask[blk_task]   <= 1'b0;
        end else if (pop) begin
            ready_mask[head_task]   <= 1'b1;
            blocked_mask[head_task] <= 1'b0;
            rd_ptr                  <= wrap_inc(rd_ptr);
            count                   <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !init) begin
            queue_q[wr_ptr] <= blk_task;
        end
    end

    // R6
    lists_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_mask & blocked_mask) == '0);

    // R7
    queue_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(blocked_mask) == int'(count));

endmodule

// File: rtl/prio_select.sv
module prio_select #(
    parameter int NUM_TASKS = 16,
    parameter int PRIO_W    = 4,
    parameter int TASK_W    = 4
) (
    input  logic [NUM_TASKS-1:0]        ready,
    input  logic [NUM_TASKS*PRIO_W-1:0] prio_flat,
    input  logic [TASK_W-1:0]           base,
    output logic                        found,
    output logic [TASK_W-1:0]           pick
);

    logic [PRIO_W-1:0] top_prio;
    logic              any_ready;

    always_comb begin
        top_prio  = '0;
        any_ready = 1'b0;
        for (int i = 0; i < NUM_TASKS; i++) begin
            if (ready[i] && (!any_ready || prio_flat[i*PRIO_W +: PRIO_W] > top_prio)) begin
                top_prio  = prio_flat[i*PRIO_W +: PRIO_W];
                any_ready = 1'b1;
            end
        end
    end

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = 0; k < NUM_TASKS; k++) begin
            int j;
            j = int'(base) + k;
            if (j >= NUM_TASKS) j = j - NUM_TASKS;
            if (!found && ready[j] && (prio_flat[j*PRIO_W +: PRIO_W] == top_prio)) begin
                found = 1'b1;
                pick  = TASK_W'(j);
            end
        end
    end

endmodule

// File: rtl/sched_monitor.sv
module sched_monitor
    import sched_mon_pkg::*;
#(
    parameter int NUM_TASKS = 16,
    parameter int PRIO_W    = 4,
    parameter int TASK_W    = $clog2(NUM_TASKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cfg_we,
    input  logic [TASK_W-1:0] cfg_task,
    input  logic [PRIO_W-1:0] cfg_prio,
    input  logic              evt_valid,
    input  logic [1:0]        evt_kind,
    input  logic              obs_valid,
    input  logic [TASK_W-1:0] obs_task,
    input  logic              err_clr,
    output logic              expect_valid,
    output logic [TASK_W-1:0] expect_task,
    output logic              err_flag,
    output logic [1:0]        err_code
);

    localparam int FLAT_W = NUM_TASKS * PRIO_W;

    mon_state_e state_q, state_d;
    evt_e       kind;

    logic [FLAT_W-1:0]    prio_flat;
    logic [NUM_TASKS-1:0] ready_mask, blocked_mask;
    logic                 head_valid;
    logic [TASK_W-1:0]    head_task;
    logic                 sel_found;
    logic [TASK_W-1:0]    sel_task;

    logic [TASK_W-1:0] cur_q, base_q, pred_q;
    logic              cur_valid_q, hold_q, pred_valid_q, preempt_q;
    logic              take_evt, do_blk, do_rel, rel_preempts;
    logic [PRIO_W-1:0] cur_prio, head_prio;
    err_e              chk_code;

    assign kind      = evt_e'(evt_kind);
    assign take_evt  = (state_q == S_RUN) && evt_valid && (kind != EV_NONE) && !start;
    assign do_blk    = take_evt && (kind == EV_BLOCK);
    assign do_rel    = take_evt && (kind == EV_RELEASE);
    assign cur_prio  = prio_flat[cur_q*PRIO_W +: PRIO_W];
    assign head_prio = prio_flat[head_task*PRIO_W +: PRIO_W];
    assign rel_preempts = head_valid && (head_prio > cur_prio);

    prio_table #(.NUM_TASKS(NUM_TASKS), .PRIO_W(PRIO_W), .TASK_W(TASK_W)) i_prio (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we && (state_q == S_IDLE)),
        .wr_task  (cfg_task),
        .wr_prio  (cfg_prio),
        .prio_flat(prio_flat)
    );

    sched_lists #(.NUM_TASKS(NUM_TASKS), .TASK_W(TASK_W)) i_lists (
        .clk         (clk),
        .rst_n       (rst_n),
        .init        (start),
        .blk         (do_blk),
        .blk_task    (cur_q),
        .rel         (do_rel),
        .ready_mask  (ready_mask),
        .blocked_mask(blocked_mask),
        .head_valid  (head_valid),
        .head_task   (head_task)
    );

    prio_select #(.NUM_TASKS(NUM_TASKS), .PRIO_W(PRIO_W), .TASK_W(TASK_W)) i_sel (
        .ready    (ready_mask),
        .prio_flat(prio_flat),
        .base     (base_q),
        .found    (sel_found),
        .pick     (sel_task)
    );

    function automatic logic [TASK_W-1:0] next_idx(input logic [TASK_W-1:0] t);
        return (t == TASK_W'(NUM_TASKS - 1)) ? '0 : t + 1'b1;
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = S_SEL;
        end else begin
            unique case (state_q)
                S_IDLE: state_d = S_IDLE;
                S_SEL:  state_d = S_WAIT;
                S_WAIT: if (obs_valid) state_d = S_RUN;
                S_RUN:  if (take_evt)  state_d = S_SEL;
                default: state_d = S_IDLE;
            endcase
        end
    end

    // classification of the observed task
    always_comb begin
        if (blocked_mask[obs_task])                   chk_code = ERR_BLOCKED;
        else if (pred_valid_q && obs_task == pred_q)  chk_code = ERR_NONE;
        else if (preempt_q && cur_valid_q && obs_task == cur_q) chk_code = ERR_MISSED;
        else                                          chk_code = ERR_WRONG;
    end

    // model datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q        <= '0;
            cur_valid_q  <= 1'b0;
            base_q       <= '0;
            hold_q       <= 1'b0;
            pred_q       <= '0;
            pred_valid_q <= 1'b0;
            preempt_q    <= 1'b0;
        end else if (start) begin
            cur_valid_q  <= 1'b0;
            base_q       <= '0;
            hold_q       <= 1'b0;
            preempt_q    <= 1'b0;
            pred_valid_q <= 1'b0;
        end else begin
            if (take_evt) begin
                base_q    <= next_idx(cur_q);
                hold_q    <= do_rel && !rel_preempts;
                preempt_q <= do_rel && rel_preempts;
            end
            if (state_q == S_SEL) begin
                pred_q       <= hold_q ? cur_q : sel_task;
                pred_valid_q <= hold_q ? cur_valid_q : sel_found;
            end
            if (state_q == S_WAIT && obs_valid) begin
                cur_q       <= obs_task;
                cur_valid_q <= 1'b1;
            end
        end
    end

    // sticky error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
            err_code <= ERR_NONE;
        end else if (state_q == S_WAIT && obs_valid && !start &&
                     chk_code != ERR_NONE && (!err_flag || err_clr)) begin
            err_flag <= 1'b1;
            err_code <= chk_code;
        end else if (err_clr) begin
            err_flag <= 1'b0;
            err_code <= ERR_NONE;
        end
    end

    // outputs
    always_comb begin
        expect_valid = (state_q == S_WAIT) && pred_valid_q;
        expect_task  = pred_q;
    end

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag);

    // R9
    err_code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> $stable(err_code));

    // R4
    obs_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && !err_clr) |=> $stable(err_flag));

    // R5
    pick_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SEL && !hold_q && sel_found) |-> ready_mask[sel_task]);

    // R2
    cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |=> $stable(prio_flat));

endmodule

// File: tb/test_sched_monitor.sv
`timescale 1ns/100ps
module test_sched_monitor;

    localparam int N  = 16;
    localparam int TW = 4;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          cfg_we = 1'b0;
    logic [TW-1:0] cfg_task = '0;
    logic [PW-1:0] cfg_prio = '0;
    logic          evt_valid = 1'b0;
    logic [1:0]    evt_kind = 2'b11;
    logic          obs_valid = 1'b0;
    logic [TW-1:0] obs_task = '0;
    logic          err_clr = 1'b0;
    logic          expect_valid;
    logic [TW-1:0] expect_task;
    logic          err_flag;
    logic [1:0]    err_code;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sched_monitor #(.NUM_TASKS(N), .PRIO_W(PW)) i_sched_monitor (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_we(cfg_we),
        .cfg_task(cfg_task), .cfg_prio(cfg_prio), .evt_valid(evt_valid),
        .evt_kind(evt_kind), .obs_valid(obs_valid), .obs_task(obs_task),
        .err_clr(err_clr), .expect_valid(expect_valid), .expect_task(expect_task),
        .err_flag(err_flag), .err_code(err_code)
    );

    // {kind, observed, expected task, expected code}
    localparam logic [11:0] VEC [0:8] = '{
        {2'b01, 4'd3,  4'd3,  2'b00},
        {2'b00, 4'd6,  4'd6,  2'b00},
        {2'b00, 4'd10, 4'd10, 2'b00},
        {2'b00, 4'd3,  4'd3,  2'b00},
        {2'b01, 4'd6,  4'd6,  2'b00},
        {2'b10, 4'd2,  4'd2,  2'b00},
        {2'b10, 4'd2,  4'd2,  2'b00},
        {2'b00, 4'd2,  4'd2,  2'b00},
        {2'b01, 4'd3,  4'd3,  2'b00}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cfg(input int t, input int p);
        @(negedge clk);
        cfg_we = 1'b1; cfg_task = TW'(t); cfg_prio = PW'(p);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_evt(input logic [1:0] k);
        @(negedge clk); evt_valid = 1'b1; evt_kind = k;
        @(negedge clk); evt_valid = 1'b0; evt_kind = 2'b11;
        @(negedge clk);
    endtask

    task automatic send_obs(input int t);
        obs_valid = 1'b1; obs_task = TW'(t);
        @(negedge clk);
        obs_valid = 1'b0;
    endtask

    task automatic clear_err();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    task automatic expect_is(input int t, input string tag);
        chk(expect_valid === 1'b1, {tag, " valid"}, int'(expect_valid), 1);
        chk(expect_task == TW'(t), {tag, " task"}, int'(expect_task), t);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(err_flag == 1'b0, "R1 flag", int'(err_flag), 0);
        chk(err_code == 2'b00, "R1 code", int'(err_code), 0);
        chk(expect_valid == 1'b0, "R1 expect_valid", int'(expect_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 configuration
        cfg(3, 7); cfg(6, 7); cfg(10, 7); cfg(2, 12); cfg(8, 4);

        // R3 start: T2 is the unique top priority
        pulse_start();
        expect_is(2, "R3 start");
        send_obs(2);
        chk(err_flag == 1'b0, "R3 match", int'(err_flag), 0);

        // R5 R6 R7 table walk
        foreach (VEC[i]) begin
            send_evt(VEC[i][11:10]);
            expect_is(int'(VEC[i][5:2]), $sformatf("R5/R6/R7 step %0d", i));
            send_obs(int'(VEC[i][9:6]));
            chk(err_code == VEC[i][1:0], $sformatf("R5/R6/R7 step %0d code", i),
                int'(err_code), int'(VEC[i][1:0]));
        end

        // R8 missed preemption: release T2 (12 > 7) but T3 keeps running
        send_evt(2'b10);
        expect_is(2, "R7 preempt");
        send_obs(3);
        chk(err_code == 2'b11, "R8 missed", int'(err_code), 3);

        // R9 sticky: later wrong observation keeps first code
        send_evt(2'b00);
        expect_is(2, "R5 tick top");
        send_obs(2);
        send_evt(2'b00);
        expect_is(2, "R5 lone top");
        send_obs(6);
        chk(err_flag == 1'b1, "R9 flag held", int'(err_flag), 1);
        chk(err_code == 2'b11, "R9 code held", int'(err_code), 3);
        clear_err();
        chk(err_flag == 1'b0, "R9 clear flag", int'(err_flag), 0);
        chk(err_code == 2'b00, "R9 clear code", int'(err_code), 0);

        // R8 blocked task observed: T6 blocks then is seen running
        send_evt(2'b01);
        expect_is(2, "R6 block");
        send_obs(6);
        chk(err_code == 2'b10, "R8 blocked", int'(err_code), 2);
        clear_err();

        // R8 wrong task
        send_evt(2'b00);
        expect_is(2, "R5 tick");
        send_obs(10);
        chk(err_code == 2'b01, "R8 wrong", int'(err_code), 1);
        clear_err();

        // R4 observation while running is not checked
        @(negedge clk);
        send_obs(5);
        chk(err_flag == 1'b0, "R4 ignored obs", int'(err_flag), 0);

        // R10 no-op event code
        send_evt(2'b11);
        chk(expect_valid == 1'b0, "R10 noop", int'(expect_valid), 0);
        send_obs(5);
        chk(err_flag == 1'b0, "R10 noop obs", int'(err_flag), 0);

        // R2 write after start ignored
        cfg(0, 15);
        send_evt(2'b00);
        expect_is(2, "R2 locked");
        send_obs(2);

        // R10 event during wait ignored
        send_evt(2'b00);
        expect_is(2, "R10 wait a");
        send_evt(2'b01);
        expect_is(2, "R10 wait b");
        send_obs(2);
        chk(err_flag == 1'b0, "R10 wait obs", int'(err_flag), 0);
        send_evt(2'b00);
        expect_is(2, "R10 not blocked");
        send_obs(2);

        // R9 start does not clear the error
        send_evt(2'b00);
        send_obs(3);
        chk(err_code == 2'b01, "R8 wrong again", int'(err_code), 1);
        pulse_start();
        chk(err_flag == 1'b1, "R9 start keeps flag", int'(err_flag), 1);
        expect_is(2, "R3 restart");
        send_obs(2);
        clear_err();

        // R7 release with empty queue
        send_evt(2'b10);
        expect_is(2, "R7 empty");
        send_obs(2);
        chk(err_flag == 1'b0, "R7 empty obs", int'(err_flag), 0);

        // R1 reset clears error, R3 tie to lowest index
        send_evt(2'b00);
        send_obs(9);
        rst_n = 1'b0;
        @(negedge clk);
        chk(err_flag == 1'b0, "R1 reset flag", int'(err_flag), 0);
        rst_n = 1'b1;
        pulse_start();
        expect_is(0, "R3 tie");
        send_obs(0);
        chk(err_flag == 1'b0, "R3 tie obs", int'(err_flag), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule